// File: doc/BRIEF.md
# Bulk Translation Entry Update Sequencer

This block turns one multi-entry update command into a series of single-entry writes on a translation table's write port. A fill command stores the same entry value into N consecutive pages. A list command fetches N 64-bit entries from memory, one 8-byte slot after another starting at a list address, and stores each one into the next page. The table sits outside the block. Memory is reached through a simple request/response read port.

Each command is validated when it is accepted. A rejected command finishes at once with a parameter-error status and touches neither port. An accepted command walks its pages one at a time. For each entry it does one read (list mode only) and then one write. It stops at the first write the table refuses. When the command completes, the block pulses `done` and presents the final status, the number of entries written, and an index that names either the last entry that succeeded or the first one that failed.

Top module: `tbus_bulk_seq`

## Requirements
- R1: After reset, `busy`, `done`, `rd_req` and `wr_req` are 0, `status` is 2'b00 and `processed` is 0.
- R2: The first write address is `cmd_bus_addr` with its low PAGE_SHIFT bits (12 by default) cleared. Each later write address is one page (4096 bytes by default) above the one before.
- R3: A list command (`cmd_op`=1) with `cmd_count` above LIST_MAX (512) ends with status 2'b01, `processed` 0, and no read or write issued. A count of exactly 512 is accepted.
- R4: A list command whose `cmd_list_addr` has any of its low 12 bits set ends with status 2'b01 and issues no read or write.
- R5: A fill command (`cmd_op`=0) with `cmd_count` above TABLE_ENTRIES (1024) ends with status 2'b01 and issues no write.
- R6: A command with `cmd_count` of 0 ends with status 2'b01. `done` is 0 in the cycle after acceptance and is a one-cycle pulse in the cycle after that.
- R7: A list command reads entry i from `cmd_list_addr + 8*i`. Byte lane k of `rd_resp_data` (bits 8k+7:8k) holds the memory byte at address+k. The entry written is big-endian: the lowest-addressed byte goes to bits 63:56.
- R8: A fill command writes `cmd_value` to every one of its N pages.
- R9: A write answered with `wr_resp_err`=1 ends the command. No further read or write is issued, and the status is 2'b10. When every write succeeds, the status is 2'b00.
- R10: At `done`, `processed` equals the number of successful writes. `last_index` is `processed`-1, or 0 when `processed` is 0.
- R11: `busy` is 1 from the cycle after acceptance until `done`. A `cmd_valid` that arrives while `busy` is 1 is ignored.
- R12: Only one entry is in flight at a time. In list mode, a write is issued only after the read response for that entry has arrived. A read is issued only after the previous write has been answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, sampled while idle |
| cmd_op | input | 1 | 0 = fill, 1 = list |
| cmd_bus_addr | input | ADDR_W | Starting bus address of the first page |
| cmd_list_addr | input | ADDR_W | Memory address of the entry list |
| cmd_count | input | CNT_W | Number of entries N |
| cmd_value | input | ENTRY_W | Entry value for fill |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 ok, 01 parameter error, 10 write failure |
| processed | output | CNT_W | Successful writes |
| last_index | output | CNT_W | Index of the last good entry or of the first failing entry |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Read address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | ENTRY_W | Read data in byte lanes |
| wr_req | output | 1 | One-cycle table write request |
| wr_addr | output | ADDR_W | Page bus address of the write |
| wr_data | output | ENTRY_W | Entry value written |
| wr_resp_valid | input | 1 | Write response valid |
| wr_resp_err | input | 1 | Write refused by the table |

## Verification
The assertions assume that memory and the table answer each request exactly once. They assume that `rd_resp_valid` and `wr_resp_valid` are raised only while a request of the same kind is outstanding, and never in the same cycle as that request. The bench's responders keep to this rule: each one records a request, waits a fixed number of cycles, and then returns a single one-cycle response. Fault injection refuses the write to one chosen page address, so a failure always lands on a known entry index.

// File: rtl/tbus_pkg.sv
package tbus_pkg;

   typedef enum logic [1:0] {
      TB_ST_OK     = 2'b00,
      TB_ST_PARAM  = 2'b01,
      TB_ST_WFAIL  = 2'b10
   } tbus_status_e;

   typedef enum logic {
      TB_OP_FILL = 1'b0,
      TB_OP_LIST = 1'b1
   } tbus_op_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_RD,
      SQ_RD_WAIT,
      SQ_WR,
      SQ_WR_WAIT,
      SQ_FIN
   } tbus_state_e;

endpackage

// File: rtl/tbus_cmd_check.sv
module tbus_cmd_check #(
   parameter int CNT_W            = 16,
   parameter int LIST_MAX         = 512,
   parameter int TABLE_ENTRIES    = 1024,
   parameter int LIST_ALIGN_SHIFT = 12
) (
   input  logic                        op_list,
   input  logic [CNT_W-1:0]            count,
   input  logic [LIST_ALIGN_SHIFT-1:0] list_low,
   output logic                        cmd_ok
);

   localparam logic [CNT_W:0] LIM_LIST  = (CNT_W+1)'(LIST_MAX);
   localparam logic [CNT_W:0] LIM_TABLE = (CNT_W+1)'(TABLE_ENTRIES);

   logic [CNT_W:0] cnt_w;
   logic           nonzero;
   logic           list_ok;
   logic           fill_ok;

   assign cnt_w   = {1'b0, count};
   assign nonzero = |count;
   assign list_ok = (cnt_w <= LIM_LIST) && (list_low == '0);
   assign fill_ok = (cnt_w <= LIM_TABLE);

   always_comb begin
      cmd_ok = 1'b0;
      if (nonzero) begin
         cmd_ok = op_list ? list_ok : fill_ok;
      end
   end

endmodule

// File: rtl/tbus_walk.sv
module tbus_walk #(
   parameter int ADDR_W     = 40,
   parameter int CNT_W      = 16,
   parameter int PAGE_SHIFT = 12,
   parameter int SLOT_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [ADDR_W-1:0] list_addr,
   input  logic [CNT_W-1:0]  count,
   output logic [ADDR_W-1:0] page_addr,
   output logic [ADDR_W-1:0] slot_addr,
   output logic [CNT_W-1:0]  idx,
   output logic              at_last
);

   localparam logic [ADDR_W-1:0] PAGE_BYTES = ADDR_W'(1) << PAGE_SHIFT;
   localparam logic [ADDR_W-1:0] PAGE_MASK  = PAGE_BYTES - ADDR_W'(1);
   localparam logic [ADDR_W-1:0] SLOT_STEP  = ADDR_W'(SLOT_BYTES);

   logic [ADDR_W-1:0] page_q;
   logic [ADDR_W-1:0] slot_q;
   logic [CNT_W-1:0]  idx_q;
   logic [CNT_W-1:0]  n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         slot_q <= '0;
         idx_q  <= '0;
         n_q    <= '0;
      end else if (load) begin
         page_q <= bus_addr & ~PAGE_MASK;
         slot_q <= list_addr;
         idx_q  <= '0;
         n_q    <= count;
      end else if (step) begin
         page_q <= page_q + PAGE_BYTES;
         slot_q <= slot_q + SLOT_STEP;
         idx_q  <= idx_q + 1'b1;
      end
   end

   assign page_addr = page_q;
   assign slot_addr = slot_q;
   assign idx       = idx_q;
   assign at_last   = (idx_q == (n_q - 1'b1));

endmodule

// File: rtl/tbus_byte_order.sv
module tbus_byte_order #(
   parameter int ENTRY_W    = 64,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [ENTRY_W-1:0] lanes,
   output logic [ENTRY_W-1:0] entry
);

   localparam int NB = ENTRY_W / 8;

   generate
      if (BIG_ENDIAN) begin : g_swap
         for (genvar b = 0; b < NB; b++) begin : g_lane
            assign entry[8*(NB-1-b) +: 8] = lanes[8*b +: 8];
         end
      end else begin : g_pass
         assign entry = lanes;
      end
   endgenerate

endmodule

// File: rtl/tbus_bulk_seq.sv
module tbus_bulk_seq #(
   parameter int ADDR_W           = 40,
   parameter int ENTRY_W          = 64,
   parameter int CNT_W            = 16,
   parameter int PAGE_SHIFT       = 12,
   parameter int LIST_MAX         = 512,
   parameter int TABLE_ENTRIES    = 1024,
   parameter int LIST_ALIGN_SHIFT = 12,
   parameter bit LIST_BIG_ENDIAN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic               cmd_op,
   input  logic [ADDR_W-1:0]  cmd_bus_addr,
   input  logic [ADDR_W-1:0]  cmd_list_addr,
   input  logic [CNT_W-1:0]   cmd_count,
   input  logic [ENTRY_W-1:0] cmd_value,
   output logic               busy,
   output logic               done,
   output logic [1:0]         status,
   output logic [CNT_W-1:0]   processed,
   output logic [CNT_W-1:0]   last_index,
   output logic               rd_req,
   output logic [ADDR_W-1:0]  rd_addr,
   input  logic               rd_resp_valid,
   input  logic [ENTRY_W-1:0] rd_resp_data,
   output logic               wr_req,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [ENTRY_W-1:0] wr_data,
   input  logic               wr_resp_valid,
   input  logic               wr_resp_err
);

   import tbus_pkg::*;

   localparam int SLOT_BYTES = ENTRY_W / 8;

   generate
      if ((ENTRY_W % 8) != 0) begin : g_bad_entry
         $error("ENTRY_W must be a whole number of bytes");
      end
      if (PAGE_SHIFT < 1 || PAGE_SHIFT >= ADDR_W) begin : g_bad_page
         $error("PAGE_SHIFT must lie inside the address");
      end
      if (LIST_ALIGN_SHIFT < 1 || LIST_ALIGN_SHIFT >= ADDR_W) begin : g_bad_align
         $error("LIST_ALIGN_SHIFT must lie inside the address");
      end
      if (CNT_W < 2 || CNT_W > 30) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if ((1 << CNT_W) <= LIST_MAX || (1 << CNT_W) <= TABLE_ENTRIES) begin : g_bad_lim
         $error("CNT_W cannot reach the count limits");
      end
   endgenerate

   tbus_state_e       state_q;
   tbus_status_e      status_q;
   logic              op_list_q;
   logic [ENTRY_W-1:0] ent_q;
   logic              done_q;

   logic              accept;
   logic              cmd_ok;
   logic              w_load;
   logic              w_step;
   logic [ADDR_W-1:0] w_page;
   logic [ADDR_W-1:0] w_slot;
   logic [CNT_W-1:0]  w_idx;
   logic              w_last;
   logic [ENTRY_W-1:0] fetched;
   logic              wr_good;

   assign accept  = cmd_valid && (state_q == SQ_IDLE);
   assign wr_good = (state_q == SQ_WR_WAIT) && wr_resp_valid && !wr_resp_err;
   assign w_load  = accept;
   assign w_step  = wr_good;

   tbus_cmd_check #(
      .CNT_W            (CNT_W),
      .LIST_MAX         (LIST_MAX),
      .TABLE_ENTRIES    (TABLE_ENTRIES),
      .LIST_ALIGN_SHIFT (LIST_ALIGN_SHIFT)
   ) u_check (
      .op_list  (cmd_op),
      .count    (cmd_count),
      .list_low (cmd_list_addr[LIST_ALIGN_SHIFT-1:0]),
      .cmd_ok   (cmd_ok)
   );

   tbus_walk #(
      .ADDR_W     (ADDR_W),
      .CNT_W      (CNT_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .SLOT_BYTES (SLOT_BYTES)
   ) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (w_load),
      .step      (w_step),
      .bus_addr  (cmd_bus_addr),
      .list_addr (cmd_list_addr),
      .count     (cmd_count),
      .page_addr (w_page),
      .slot_addr (w_slot),
      .idx       (w_idx),
      .at_last   (w_last)
   );

   tbus_byte_order #(
      .ENTRY_W    (ENTRY_W),
      .BIG_ENDIAN (LIST_BIG_ENDIAN)
   ) u_order (
      .lanes (rd_resp_data),
      .entry (fetched)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         status_q  <= TB_ST_OK;
         op_list_q <= 1'b0;
         ent_q     <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SQ_IDLE: begin
               if (cmd_valid) begin
                  op_list_q <= cmd_op;
                  ent_q     <= cmd_value;
                  if (!cmd_ok) begin
                     status_q <= TB_ST_PARAM;
                     state_q  <= SQ_FIN;
                  end else begin
                     status_q <= TB_ST_OK;
                     state_q  <= (cmd_op == TB_OP_LIST) ? SQ_RD : SQ_WR;
                  end
               end
            end
            SQ_RD: begin
               state_q <= SQ_RD_WAIT;
            end
            SQ_RD_WAIT: begin
               if (rd_resp_valid) begin
                  ent_q   <= fetched;
                  state_q <= SQ_WR;
               end
            end
            SQ_WR: begin
               state_q <= SQ_WR_WAIT;
            end
            SQ_WR_WAIT: begin
               if (wr_resp_valid) begin
                  if (wr_resp_err) begin
                     status_q <= TB_ST_WFAIL;
                     state_q  <= SQ_FIN;
                  end else if (w_last) begin
                     state_q <= SQ_FIN;
                  end else begin
                     state_q <= op_list_q ? SQ_RD : SQ_WR;
                  end
               end
            end
            SQ_FIN: begin
               done_q  <= 1'b1;
               state_q <= SQ_IDLE;
            end
            default: begin
               state_q <= SQ_IDLE;
            end
         endcase
      end
   end

   assign busy       = (state_q != SQ_IDLE);
   assign done       = done_q;
   assign status     = status_q;
   assign processed  = w_idx;
   assign last_index = (w_idx == '0) ? '0 : (w_idx - 1'b1);
   assign rd_req     = (state_q == SQ_RD);
   assign rd_addr    = w_slot;
   assign wr_req     = (state_q == SQ_WR);
   assign wr_addr    = w_page;
   assign wr_data    = ent_q;

endmodule

// File: rtl/tbus_bulk_seq_chk.sv
module tbus_bulk_seq_chk #(
   parameter int ADDR_W     = 40,
   parameter int CNT_W      = 16,
   parameter int PAGE_SHIFT = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic [1:0]        status,
   input logic [CNT_W-1:0]  processed,
   input logic              rd_req,
   input logic              rd_resp_valid,
   input logic              wr_req,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_resp_valid,
   input logic              wr_resp_err
);

   logic rd_out;
   logic wr_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_out <= 1'b0;
         wr_out <= 1'b0;
      end else begin
         if (rd_req) rd_out <= 1'b1;
         else if (rd_resp_valid) rd_out <= 1'b0;
         if (wr_req) wr_out <= 1'b1;
         else if (wr_resp_valid) wr_out <= 1'b0;
      end
   end

   // R12: a write never overlaps an unanswered read
   p_wr_after_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> !rd_out);

   // R12: a read never overlaps an unanswered write
   p_rd_after_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !wr_out);

   // R2: writes land on page boundaries
   p_page_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> (wr_addr[PAGE_SHIFT-1:0] == '0));

   // R6: done is a single-cycle pulse
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11: done follows a busy period
   p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   // R3: a rejected command reports no work
   p_param_no_work_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'b01) |-> (processed == '0));

   // R9: a refused write ends the command with the failure status
   p_fail_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_out && wr_resp_valid && wr_resp_err) |=> ##1 (done && status == 2'b10));

endmodule

bind tbus_bulk_seq tbus_bulk_seq_chk #(
   .ADDR_W     (ADDR_W),
   .CNT_W      (CNT_W),
   .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (busy),
   .done          (done),
   .status        (status),
   .processed     (processed),
   .rd_req        (rd_req),
   .rd_resp_valid (rd_resp_valid),
   .wr_req        (wr_req),
   .wr_addr       (wr_addr),
   .wr_resp_valid (wr_resp_valid),
   .wr_resp_err   (wr_resp_err)
);

// File: tb/sim_tbus_bulk_seq.sv
`timescale 1ns/1ps
module sim_tbus_bulk_seq;

   localparam int AW = 40;
   localparam int EW = 64;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_op = 1'b0;
   logic [AW-1:0] cmd_bus_addr = '0;
   logic [AW-1:0] cmd_list_addr = '0;
   logic [CW-1:0] cmd_count = '0;
   logic [EW-1:0] cmd_value = '0;
   logic          busy, done;
   logic [1:0]    status;
   logic [CW-1:0] processed, last_index;
   logic          rd_req, wr_req;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [EW-1:0] wr_data;
   logic          rd_resp_valid = 1'b0;
   logic [EW-1:0] rd_resp_data = '0;
   logic          wr_resp_valid = 1'b0;
   logic          wr_resp_err = 1'b0;

   always #10 clk = ~clk;

   tbus_bulk_seq u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_bus_addr(cmd_bus_addr), .cmd_list_addr(cmd_list_addr),
      .cmd_count(cmd_count), .cmd_value(cmd_value), .busy(busy), .done(done),
      .status(status), .processed(processed), .last_index(last_index),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_resp_valid(rd_resp_valid),
      .rd_resp_data(rd_resp_data), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_resp_valid(wr_resp_valid), .wr_resp_err(wr_resp_err)
   );

   int n_chk = 0;
   int n_bad = 0;

   // memory model and responders
   logic          fail_en = 1'b0;
   logic [AW-1:0] fail_addr = '0;
   logic          list_mode = 1'b0;
   logic [AW-1:0] wlog_a [0:1023];
   logic [EW-1:0] wlog_d [0:1023];
   int            wr_n = 0;
   int            rd_n = 0;
   int            order_err = 0;
   int            rd_cnt = 0;
   logic [AW-1:0] rd_a = '0;
   logic          wr_pend = 1'b0;
   logic [AW-1:0] wr_pa = '0;
   logic          got_rd = 1'b0;

   function automatic logic [7:0] mb(input logic [AW-1:0] a);
      return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5C;
   endfunction

   function automatic logic [EW-1:0] lanes_at(input logic [AW-1:0] a);
      logic [EW-1:0] v;
      for (int k = 0; k < 8; k++) v[8*k +: 8] = mb(a + AW'(k));
      return v;
   endfunction

   function automatic logic [EW-1:0] be_at(input logic [AW-1:0] a);
      logic [EW-1:0] v;
      for (int k = 0; k < 8; k++) v[8*(7-k) +: 8] = mb(a + AW'(k));
      return v;
   endfunction

   always @(negedge clk) begin
      rd_resp_valid <= 1'b0;
      wr_resp_valid <= 1'b0;
      wr_resp_err   <= 1'b0;
      if (rd_cnt == 1) begin
         rd_resp_valid <= 1'b1;
         rd_resp_data  <= lanes_at(rd_a);
         got_rd        <= 1'b1;
      end
      if (rd_cnt != 0) rd_cnt <= rd_cnt - 1;
      if (wr_pend) begin
         wr_resp_valid <= 1'b1;
         wr_resp_err   <= fail_en && (wr_pa == fail_addr);
         wr_pend       <= 1'b0;
      end
      if (rd_req) begin
         if (rd_cnt != 0 || wr_pend) order_err <= order_err + 1;
         rd_a   <= rd_addr;
         rd_cnt <= 2;
         rd_n   <= rd_n + 1;
      end
      if (wr_req) begin
         if (list_mode && !got_rd) order_err <= order_err + 1;
         if (rd_cnt != 0) order_err <= order_err + 1;
         got_rd <= 1'b0;
         if (wr_n < 1024) begin
            wlog_a[wr_n] <= wr_addr;
            wlog_d[wr_n] <= wr_data;
         end
         wr_n    <= wr_n + 1;
         wr_pa   <= wr_addr;
         wr_pend <= 1'b1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // results of the last command
   logic [1:0]    r_st;
   logic [CW-1:0] r_proc, r_last;
   int            wr_base, rd_base;

   task automatic issue(input logic op, input logic [AW-1:0] ba,
                        input logic [AW-1:0] la, input int n,
                        input logic [EW-1:0] val);
      @(negedge clk);
      cmd_op = op; cmd_bus_addr = ba; cmd_list_addr = la;
      cmd_count = CW'(n); cmd_value = val; cmd_valid = 1'b1;
      list_mode = op;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_done();
      int t;
      t = 0;
      while (!done && t < 20000) begin
         @(negedge clk);
         t++;
      end
      chk(done == 1'b1, "R11 done seen", 64'(done), 64'd1);
      r_st = status; r_proc = processed; r_last = last_index;
      repeat (4) @(negedge clk);
   endtask

   task automatic run(input logic op, input logic [AW-1:0] ba,
                      input logic [AW-1:0] la, input int n,
                      input logic [EW-1:0] val);
      wr_base = wr_n; rd_base = rd_n;
      issue(op, ba, la, n, val);
      wait_done();
   endtask

   task automatic t_reset();
      chk(!busy && !done && !rd_req && !wr_req, "R1 idle outputs",
          64'({busy, done, rd_req, wr_req}), 64'd0);
      chk(status == 2'b00 && processed == '0, "R1 status/count",
          64'({status, processed}), 64'd0);
   endtask

   task automatic t_fill_basic();
      logic [AW-1:0] base;
      base = 40'h12_3456_7ABC;
      run(1'b0, base, '0, 4, 64'hDEAD_BEEF_0000_1003);
      chk(r_st == 2'b00, "R9 fill ok status", 64'(r_st), 64'd0);
      chk(r_proc == 4 && r_last == 3, "R10 fill count/index",
          64'({r_proc, r_last}), 64'({16'd4, 16'd3}));
      chk(wr_n - wr_base == 4 && rd_n == rd_base, "R8 fill write count",
          64'(wr_n - wr_base), 64'd4);
      for (int i = 0; i < 4; i++) begin
         chk(wlog_a[wr_base+i] == 40'h12_3456_7000 + AW'(i) * AW'(4096),
             "R2 page address", 64'(wlog_a[wr_base+i]),
             64'(40'h12_3456_7000 + AW'(i) * AW'(4096)));
         chk(wlog_d[wr_base+i] == 64'hDEAD_BEEF_0000_1003, "R8 fill value",
             wlog_d[wr_base+i], 64'hDEAD_BEEF_0000_1003);
      end
   endtask

   task automatic t_list_basic();
      logic [AW-1:0] la;
      int oe;
      la = 40'h00_0008_3000;
      oe = order_err;
      run(1'b1, 40'h00_4000_0010, la, 3, '0);
      chk(r_st == 2'b00 && r_proc == 3, "R7 list status/count",
          64'({r_st, r_proc}), 64'({2'b00, 16'd3}));
      chk(rd_n - rd_base == 3 && wr_n - wr_base == 3, "R12 one read per write",
          64'(rd_n - rd_base), 64'd3);
      chk(order_err == oe, "R12 ordering", 64'(order_err - oe), 64'd0);
      for (int i = 0; i < 3; i++) begin
         chk(wlog_d[wr_base+i] == be_at(la + AW'(8*i)), "R7 big-endian entry",
             wlog_d[wr_base+i], be_at(la + AW'(8*i)));
         chk(wlog_a[wr_base+i] == 40'h00_4000_0000 + AW'(i) * AW'(4096),
             "R2 list page address", 64'(wlog_a[wr_base+i]),
             64'(40'h00_4000_0000 + AW'(i) * AW'(4096)));
      end
   endtask

   task automatic t_list_limits();
      run(1'b1, 40'h0, 40'h00_0010_0000, 513, '0);
      chk(r_st == 2'b01 && r_proc == 0, "R3 513 rejected",
          64'({r_st, r_proc}), 64'({2'b01, 16'd0}));
      chk(rd_n == rd_base && wr_n == wr_base, "R3 no access",
          64'(rd_n - rd_base + wr_n - wr_base), 64'd0);
      run(1'b1, 40'h0, 40'h00_0010_0000, 512, '0);
      chk(r_st == 2'b00 && r_proc == 512 && r_last == 511, "R3 512 accepted",
          64'({r_st, r_proc, r_last}), 64'({2'b00, 16'd512, 16'd511}));
      chk(wlog_d[wr_base+511] == be_at(40'h00_0010_0000 + AW'(8*511)),
          "R7 last slot", wlog_d[wr_base+511],
          be_at(40'h00_0010_0000 + AW'(8*511)));
   endtask

   task automatic t_list_misaligned();
      run(1'b1, 40'h0, 40'h00_0010_0008, 2, '0);
      chk(r_st == 2'b01, "R4 misaligned list", 64'(r_st), 64'd1);
      chk(rd_n == rd_base && wr_n == wr_base, "R4 no access",
          64'(rd_n - rd_base + wr_n - wr_base), 64'd0);
   endtask

   task automatic t_fill_limit();
      run(1'b0, 40'h0, '0, 1025, 64'h1);
      chk(r_st == 2'b01 && wr_n == wr_base, "R5 fill over table",
          64'({r_st}), 64'd1);
   endtask

   task automatic t_zero();
      wr_base = wr_n;
      issue(1'b0, 40'h0, '0, 0, 64'h7);
      chk(!done && busy, "R6 no done one cycle after accept", 64'({done, busy}), 64'b01);
      @(negedge clk);
      chk(done && status == 2'b01, "R6 zero count done+param",
          64'({done, status}), 64'b101);
      chk(wr_n == wr_base, "R6 no write", 64'(wr_n - wr_base), 64'd0);
      @(negedge clk);
      chk(!done, "R6 done pulse", 64'(done), 64'd0);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_fail_mid();
      fail_en = 1'b1; fail_addr = 40'h00_0020_2000;
      run(1'b0, 40'h00_0020_0000, '0, 5, 64'hA5);
      fail_en = 1'b0;
      chk(r_st == 2'b10, "R9 write failure status", 64'(r_st), 64'd2);
      chk(wr_n - wr_base == 3, "R9 stop after failing write", 64'(wr_n - wr_base), 64'd3);
      chk(r_proc == 2 && r_last == 1, "R10 count/index at failure",
          64'({r_proc, r_last}), 64'({16'd2, 16'd1}));
   endtask

   task automatic t_fail_first();
      fail_en = 1'b1; fail_addr = 40'h00_0030_0000;
      run(1'b1, 40'h00_0030_0000, 40'h00_0040_0000, 4, '0);
      fail_en = 1'b0;
      chk(r_st == 2'b10 && r_proc == 0 && r_last == 0, "R10 first entry fails",
          64'({r_st, r_proc, r_last}), 64'({2'b10, 16'd0, 16'd0}));
      chk(rd_n - rd_base == 1 && wr_n - wr_base == 1, "R9 no later access",
          64'(rd_n - rd_base + wr_n - wr_base), 64'd2);
   endtask

   task automatic t_busy_ignore();
      wr_base = wr_n; rd_base = rd_n;
      issue(1'b0, 40'h00_0050_0000, '0, 3, 64'h33);
      chk(busy, "R11 busy after accept", 64'(busy), 64'd1);
      @(negedge clk);
      cmd_op = 1'b1; cmd_bus_addr = 40'h00_0060_0000;
      cmd_list_addr = 40'h00_0070_0000; cmd_count = 16'd2; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_done();
      chk(wr_n - wr_base == 3 && rd_n == rd_base, "R11 extra command ignored",
          64'(wr_n - wr_base), 64'd3);
      chk(wlog_a[wr_base+2] == 40'h00_0050_2000 && wlog_d[wr_base+2] == 64'h33,
          "R11 original command kept", 64'(wlog_a[wr_base+2]), 64'h50_2000);
      repeat (10) @(negedge clk);
      chk(!busy && wr_n - wr_base == 3, "R11 stays idle", 64'(busy), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill_basic();
      t_list_basic();
      t_list_limits();
      t_list_misaligned();
      t_fill_limit();
      t_zero();
      t_fail_mid();
      t_fail_first();
      t_busy_ignore();
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
      $finish;
   end

endmodule